// File: doc/BRIEF.md
# Power Mode and Reset Controller

This block decides when a small controller core runs, sleeps or is held in reset. It takes an oscillator-rate clock, the external reset pin, software requests for the two sleep modes and a flag that says an enabled interrupt is waiting. From these it drives clock enables for the CPU and for the peripherals, an enable for the oscillator, a synchronous core reset, a hold signal for the external memory strobes, and the external-access strap value seen by the core.

The clock first passes through a divide-by-two stage. All timing inside the block is counted in these half-rate phases, so the input duty cycle does not matter. A reset pin pulse is only accepted after it has stayed high for two machine cycles (twelve phases, twenty-four oscillator periods) while the oscillator runs. Light sleep stops only the CPU clock and ends on an interrupt or an accepted reset. Deep sleep stops the oscillator and ends only on an accepted reset, which first restarts the oscillator and then holds the core in reset for a start-up count before any clock is enabled. RAM contents are outside this block and are assumed kept through every mode.

When the first lock bit is programmed, the external-access strap is sampled while the core is in reset and held until the next reset; otherwise the live strap level is passed on.

Top module: `pwr_rst_ctrl`

## Requirements
- R1: While `por` is high, and afterwards until `rst_pin` is seen low, `core_rst`, `cpu_clk_en`, `per_clk_en` and `osc_run` are all 1; a few cycles after `rst_pin` falls the block is running with `core_rst` 0 and all three enables 1.
- R2: While running, a reset pin pulse held high for 30 clock periods raises `core_rst`; a pulse of 18 periods or less never raises it.
- R3: A one-cycle `idle_req` while running gives `cpu_clk_en` 0, `per_clk_en` 1, `osc_run` 1 and `strobe_hold` 1 within two cycles.
- R4: In light sleep, `irq_pend` returns the block to running (`cpu_clk_en` 1, `strobe_hold` 0) within two cycles.
- R5: In light sleep, an accepted reset pin pulse raises `core_rst`.
- R6: A `pd_req` while running gives `cpu_clk_en`, `per_clk_en` and `osc_run` all 0; when `pd_req` and `idle_req` arrive together, deep sleep wins.
- R7: In deep sleep `irq_pend` has no effect: all enables stay 0.
- R8: In deep sleep a long reset pin pulse sets `osc_run` 1, then gives `core_rst` 1 with `cpu_clk_en` and `per_clk_en` 0 for `STARTUP_PH` phases, then `core_rst` 1 with both enables 1 until the pin falls.
- R9: In deep sleep a reset pin pulse too short to be accepted restarts the oscillator only while the pin is high; after it falls the block returns to deep sleep with `osc_run` 0.
- R10: With `lock1_prog` 1, `ea_latched` takes the `ea_pin` level present while the core is in reset and then holds it regardless of later `ea_pin` changes.
- R11: With `lock1_prog` 0, `ea_latched` equals the present `ea_pin` level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| por | input | 1 | Synchronous power-on reset, active high |
| rst_pin | input | 1 | External reset pin, asynchronous, active high |
| idle_req | input | 1 | Software request for light sleep |
| pd_req | input | 1 | Software request for deep sleep |
| irq_pend | input | 1 | An enabled interrupt is pending |
| ea_pin | input | 1 | External-access strap level |
| lock1_prog | input | 1 | First lock bit programmed |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_run | output | 1 | Oscillator run enable |
| core_rst | output | 1 | Synchronous core reset |
| strobe_hold | output | 1 | Holds the external memory strobes high |
| ea_latched | output | 1 | Strap value used by the core |

## Verification
The hardest situation to reach is the wake from deep sleep, because the filter only counts while the oscillator runs and the oscillator is off in that mode. The stimulus parks the block in deep sleep, raises the pin and keeps it high, then samples the outputs at a point inside the start-up window and again well after it, so the order oscillator, held reset, then clocks is seen. A short pin pulse in deep sleep checks that an unaccepted wake attempt falls back to sleep with the oscillator stopped.

// File: rtl/pm_pkg.sv
package pm_pkg;

    typedef enum logic [2:0] {
        ST_RESET = 3'd0,
        ST_RUN   = 3'd1,
        ST_IDLE  = 3'd2,
        ST_PDOWN = 3'd3,
        ST_WAKE  = 3'd4,
        ST_START = 3'd5
    } pm_state_e;

    typedef struct packed {
        logic cpu_en;
        logic per_en;
        logic osc_en;
        logic core_rst;
        logic strobe_hold;
    } pm_ctl_t;

    // Output pattern for each state
    function automatic pm_ctl_t ctl_for(pm_state_e s);
        pm_ctl_t c;
        case (s)
            ST_RESET: c = '{cpu_en: 1'b1, per_en: 1'b1, osc_en: 1'b1, core_rst: 1'b1, strobe_hold: 1'b0};
            ST_RUN:   c = '{cpu_en: 1'b1, per_en: 1'b1, osc_en: 1'b1, core_rst: 1'b0, strobe_hold: 1'b0};
            ST_IDLE:  c = '{cpu_en: 1'b0, per_en: 1'b1, osc_en: 1'b1, core_rst: 1'b0, strobe_hold: 1'b1};
            ST_PDOWN: c = '{cpu_en: 1'b0, per_en: 1'b0, osc_en: 1'b0, core_rst: 1'b0, strobe_hold: 1'b0};
            ST_WAKE:  c = '{cpu_en: 1'b0, per_en: 1'b0, osc_en: 1'b1, core_rst: 1'b0, strobe_hold: 1'b0};
            ST_START: c = '{cpu_en: 1'b0, per_en: 1'b0, osc_en: 1'b1, core_rst: 1'b1, strobe_hold: 1'b0};
            default:  c = '{cpu_en: 1'b1, per_en: 1'b1, osc_en: 1'b1, core_rst: 1'b1, strobe_hold: 1'b0};
        endcase
        return c;
    endfunction

    // Phases the reset pin must stay high before acceptance
    function automatic int filt_limit(int phases_per_mc, int n_mc);
        return phases_per_mc * n_mc;
    endfunction

endpackage

// File: rtl/pm_phase_div.sv
module pm_phase_div (
    input  logic clk,
    input  logic por,
    input  logic osc_en,
    output logic tick
);
    logic phase_q;

    always_ff @(posedge clk) begin
        if (por)
            phase_q <= 1'b0;
        else if (osc_en)
            phase_q <= ~phase_q;
    end

    // one tick per two oscillator periods, only while the oscillator runs
    assign tick = osc_en & phase_q;

    // R2
    phase_toggle_chk: assert property (@(posedge clk) disable iff (por)
        osc_en |=> (phase_q != $past(phase_q)));

    // R7
    phase_frozen_chk: assert property (@(posedge clk) disable iff (por)
        !osc_en |=> $stable(phase_q));
endmodule

// File: rtl/pm_rst_filter.sv
module pm_rst_filter #(
    parameter int SYNC_STAGES   = 2,
    parameter int PHASES_PER_MC = 6,
    parameter int RST_MC        = 2
) (
    input  logic clk,
    input  logic por,
    input  logic rst_pin,
    input  logic tick,
    output logic pin_high,
    output logic accept
);
    localparam int LIMIT = pm_pkg::filt_limit(PHASES_PER_MC, RST_MC);
    localparam int CW    = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          cnt_q;

    // synchronizer presets to "pin high" so a release is seen only after por
    always_ff @(posedge clk) begin
        if (por)
            sync_q <= '1;
        else
            sync_q <= {sync_q[SYNC_STAGES-2:0], rst_pin};
    end

    assign pin_high = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (por || !pin_high)
            cnt_q <= '0;
        else if (tick && (cnt_q != LIM_V))
            cnt_q <= cnt_q + 1'b1;
    end

    assign accept = pin_high && (cnt_q == LIM_V);

    // R2
    filt_bound_chk: assert property (@(posedge clk) disable iff (por)
        cnt_q <= LIM_V);

    // R2
    filt_clear_chk: assert property (@(posedge clk) disable iff (por)
        !pin_high |=> (cnt_q == '0));

    // R2
    filt_step_chk: assert property (@(posedge clk) disable iff (por)
        (pin_high && !tick) |=> $stable(cnt_q) || (cnt_q == '0));
endmodule

// File: rtl/pm_ea_latch.sv
module pm_ea_latch (
    input  logic clk,
    input  logic por,
    input  logic capture,
    input  logic lock_en,
    input  logic ea_pin,
    output logic ea_out
);
    logic ea_q;

    always_ff @(posedge clk) begin
        if (por)
            ea_q <= 1'b0;
        else if (capture)
            ea_q <= ea_pin;
    end

    assign ea_out = lock_en ? ea_q : ea_pin;

    // R10
    ea_hold_chk: assert property (@(posedge clk) disable iff (por)
        !capture |=> $stable(ea_q));

    // R11
    ea_pass_chk: assert property (@(posedge clk) disable iff (por)
        !lock_en |-> (ea_out == ea_pin));
endmodule

// File: rtl/pwr_rst_ctrl.sv
module pwr_rst_ctrl #(
    parameter int SYNC_STAGES   = 2,
    parameter int PHASES_PER_MC = 6,
    parameter int RST_MC        = 2,
    parameter int STARTUP_PH    = 32
) (
    input  logic clk,
    input  logic por,
    input  logic rst_pin,
    input  logic idle_req,
    input  logic pd_req,
    input  logic irq_pend,
    input  logic ea_pin,
    input  logic lock1_prog,
    output logic cpu_clk_en,
    output logic per_clk_en,
    output logic osc_run,
    output logic core_rst,
    output logic strobe_hold,
    output logic ea_latched
);
    import pm_pkg::*;

    localparam int SW = $clog2(STARTUP_PH + 1);
    localparam logic [SW-1:0] START_LAST = SW'(STARTUP_PH - 1);

    pm_state_e state_q, state_d;
    pm_ctl_t   ctl;
    logic      tick, pin_high, rst_acc, start_done;
    logic [SW-1:0] start_q;

    assign ctl = ctl_for(state_q);

    pm_phase_div u_div (
        .clk    (clk),
        .por    (por),
        .osc_en (ctl.osc_en),
        .tick   (tick)
    );

    pm_rst_filter #(
        .SYNC_STAGES   (SYNC_STAGES),
        .PHASES_PER_MC (PHASES_PER_MC),
        .RST_MC        (RST_MC)
    ) u_filt (
        .clk      (clk),
        .por      (por),
        .rst_pin  (rst_pin),
        .tick     (tick),
        .pin_high (pin_high),
        .accept   (rst_acc)
    );

    pm_ea_latch u_ea (
        .clk     (clk),
        .por     (por),
        .capture (state_q == ST_RESET),
        .lock_en (lock1_prog),
        .ea_pin  (ea_pin),
        .ea_out  (ea_latched)
    );

    // start-up counter, in phases, after a deep-sleep wake is accepted
    always_ff @(posedge clk) begin
        if (por || state_q != ST_START)
            start_q <= '0;
        else if (tick && !start_done)
            start_q <= start_q + 1'b1;
    end

    assign start_done = tick && (start_q == START_LAST);

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_RESET: if (!pin_high) state_d = ST_RUN;
            ST_RUN: begin
                if (rst_acc)       state_d = ST_RESET;
                else if (pd_req)   state_d = ST_PDOWN;
                else if (idle_req) state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (rst_acc)       state_d = ST_RESET;
                else if (irq_pend) state_d = ST_RUN;
            end
            ST_PDOWN: if (pin_high) state_d = ST_WAKE;
            ST_WAKE: begin
                if (rst_acc)        state_d = ST_START;
                else if (!pin_high) state_d = ST_PDOWN;
            end
            ST_START: if (start_done) state_d = ST_RESET;
            default: state_d = ST_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (por)
            state_q <= ST_RESET;
        else
            state_q <= state_d;
    end

    assign cpu_clk_en  = ctl.cpu_en;
    assign per_clk_en  = ctl.per_en;
    assign osc_run     = ctl.osc_en;
    assign core_rst    = ctl.core_rst;
    assign strobe_hold = ctl.strobe_hold;

    // R4
    idle_wake_chk: assert property (@(posedge clk) disable iff (por)
        (state_q == ST_IDLE && irq_pend && !rst_acc) |=> (state_q == ST_RUN));

    // R7
    pd_stay_chk: assert property (@(posedge clk) disable iff (por)
        (state_q == ST_PDOWN && !pin_high) |=> (state_q == ST_PDOWN));

    // R6
    pd_priority_chk: assert property (@(posedge clk) disable iff (por)
        (state_q == ST_RUN && pd_req && !rst_acc) |=> (state_q == ST_PDOWN));

    // R8
    start_hold_chk: assert property (@(posedge clk) disable iff (por)
        (state_q == ST_START && !start_done) |=> (state_q == ST_START));

    // R5
    rst_take_chk: assert property (@(posedge clk) disable iff (por)
        (rst_acc && (state_q == ST_RUN || state_q == ST_IDLE)) |=> core_rst);

    // R8
    wake_osc_chk: assert property (@(posedge clk) disable iff (por)
        $rose(osc_run) |-> $past(pin_high));
endmodule

// File: tb/pwr_rst_ctrl_test.sv
module pwr_rst_ctrl_test;
    logic clk = 1'b0;
    logic por, rst_pin, idle_req, pd_req, irq_pend, ea_pin, lock1_prog;
    logic cpu_clk_en, per_clk_en, osc_run, core_rst, strobe_hold, ea_latched;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    localparam int STARTUP_PH = 32;

    always #10 clk = ~clk;

    pwr_rst_ctrl #(.STARTUP_PH(STARTUP_PH)) uut (
        .clk(clk), .por(por), .rst_pin(rst_pin), .idle_req(idle_req),
        .pd_req(pd_req), .irq_pend(irq_pend), .ea_pin(ea_pin),
        .lock1_prog(lock1_prog), .cpu_clk_en(cpu_clk_en),
        .per_clk_en(per_clk_en), .osc_run(osc_run), .core_rst(core_rst),
        .strobe_hold(strobe_hold), .ea_latched(ea_latched)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // enables packed as {cpu, per, osc, rst}
    function automatic logic [31:0] en4();
        return {28'd0, cpu_clk_en, per_clk_en, osc_run, core_rst};
    endfunction

    task automatic t_power_on();
        por = 1; rst_pin = 1; idle_req = 0; pd_req = 0; irq_pend = 0;
        ea_pin = 1; lock1_prog = 1;
        cyc(4);
        chk("R1 por", en4(), 32'hF);
        por = 0;
        cyc(6);
        chk("R1 held by pin", en4(), 32'hF);
        rst_pin = 0;
        cyc(5);
        chk("R1 running", en4(), 32'hE);
        ea_pin = 0;
        cyc(2);
        chk("R10 held 1", ea_latched, 1);
    endtask

    task automatic t_short_run();
        bit seen = 0;
        rst_pin = 1;
        for (int i = 0; i < 18; i++) begin cyc(1); if (core_rst) seen = 1; end
        rst_pin = 0;
        for (int i = 0; i < 10; i++) begin cyc(1); if (core_rst) seen = 1; end
        chk("R2 short ignored", seen, 0);
    endtask

    task automatic t_long_run();
        ea_pin = 0;
        rst_pin = 1;
        cyc(30);
        chk("R2 long accepted", core_rst, 1);
        cyc(2);
        rst_pin = 0;
        cyc(5);
        chk("R2 back to run", en4(), 32'hE);
        ea_pin = 1;
        cyc(2);
        chk("R10 captured 0", ea_latched, 0);
    endtask

    task automatic t_idle();
        idle_req = 1; cyc(1); idle_req = 0;
        cyc(2);
        chk("R3 idle enables", en4(), 32'h6);
        chk("R3 strobe hold", strobe_hold, 1);
        irq_pend = 1; cyc(1); irq_pend = 0;
        cyc(1);
        chk("R4 wake enables", en4(), 32'hE);
        chk("R4 strobe free", strobe_hold, 0);
    endtask

    task automatic t_idle_reset();
        idle_req = 1; cyc(1); idle_req = 0;
        cyc(2);
        rst_pin = 1;
        cyc(30);
        chk("R5 reset from idle", core_rst, 1);
        rst_pin = 0;
        cyc(5);
        chk("R5 run after", en4(), 32'hE);
    endtask

    task automatic t_pdown();
        idle_req = 1; pd_req = 1; cyc(1); idle_req = 0; pd_req = 0;
        cyc(2);
        chk("R6 deep sleep", en4(), 32'h0);
        irq_pend = 1;
        cyc(5);
        chk("R7 irq ignored", en4(), 32'h0);
        irq_pend = 0;
        cyc(2);
        chk("R7 still down", osc_run, 0);
    endtask

    task automatic t_pd_short();
        rst_pin = 1;
        cyc(6);
        chk("R9 osc restarted", osc_run, 1);
        chk("R9 no reset", core_rst, 0);
        cyc(4);
        rst_pin = 0;
        cyc(6);
        chk("R9 back down", en4(), 32'h0);
    endtask

    task automatic t_pd_wake();
        rst_pin = 1;
        cyc(6);
        chk("R8 osc up", osc_run, 1);
        cyc(26);
        chk("R8 startup held", en4(), 32'h3);
        cyc(118);
        chk("R8 reset clocked", en4(), 32'hF);
        rst_pin = 0;
        cyc(5);
        chk("R8 running", en4(), 32'hE);
    endtask

    task automatic t_no_lock();
        lock1_prog = 0;
        ea_pin = 1; cyc(1);
        chk("R11 follow 1", ea_latched, 1);
        ea_pin = 0; cyc(1);
        chk("R11 follow 0", ea_latched, 0);
    endtask

    initial begin
        t_power_on();
        t_short_run();
        t_long_run();
        t_idle();
        t_idle_reset();
        t_pdown();
        t_pd_short();
        t_pd_wake();
        t_no_lock();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule